// File: doc/BRIEF.md
# Piecewise-Linear Activation Unit

This block applies a programmable nonlinear activation to a vector of fixed-point values. It approximates a smooth function such as a sigmoid with a straight line on each of 16 segments. Each lane finds the segment its input falls in by comparing it against a set of breakpoints. It then computes `slope * x + intercept` with that segment's coefficients and saturates the result. All lanes share one coefficient set, and each lane may select a different segment in the same cycle.

The unit sits after the accumulation stage of a neural-network datapath. Convolutional and classifier layers send their sums through the activation. Pooling layers set a bypass flag, and the inputs then pass through unchanged with the same latency. A register-write port loads slopes, intercepts and breakpoints. Writes go to a shadow copy that becomes active only on a cycle with no incoming vector, so the coefficient set never changes while a stream of back-to-back vectors is being accepted.

Top module: `pla_activation`

## Requirements
- R1: After synchronous reset, `out_valid` and `out_data` are 0 and every coefficient and breakpoint is zero, so an activated vector then yields all-zero lanes.
- R2: A vector presented with `in_valid` high at a rising edge appears on `out_data` with `out_valid` high two rising edges later. When `in_valid` is low, `out_valid` is low two edges later.
- R3: The segment for input x is the number of breakpoints k (0..14) with x >= bp[k], compared as signed values. With ascending breakpoints, x below bp[0] uses segment 0, x at or above bp[14] uses segment 15, and x equal to bp[k] uses segment k+1.
- R4: For a non-bypassed lane, each value is signed 16-bit with 8 fraction bits. The result is floor((a*x + 128) / 256) + b, where a and b are the selected segment's slope and intercept.
- R5: A result above 32767 is clamped to 32767 (0x7FFF), and a result below -32768 is clamped to -32768 (0x8000).
- R6: When `in_bypass` is high with a vector, every output lane equals its input lane.
- R7: The write port maps `cfg_addr` 0..15 to the slope of segment 0..15, 16..31 to the intercept of segment 0..15, and 32..46 to breakpoint 0..14. Writes to addresses 47..63 change nothing.
- R8: A written value is used only by vectors accepted after a rising edge at which `in_valid` was low and the write had already completed. Vectors accepted while `in_valid` stays high continuously use the previously active set.
- R9: Lane i occupies bits [16*i+15:16*i] of `in_data` and `out_data`. Each lane selects its segment independently of the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present |
| in_bypass | input | 1 | Pass the vector through unchanged (pooling) |
| in_data | input | 64 | Four signed Q8.8 lanes |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 6 | Coefficient write address |
| cfg_wdata | input | 16 | Coefficient write data |
| out_valid | output | 1 | Output vector present |
| out_data | output | 64 | Four signed Q8.8 results |

## Verification
On every cycle, the assertions check the fixed two-edge valid delay and that bypassed data passes through untouched. They also check that the active coefficient set stays frozen across a continuous run of incoming vectors, and that segment selection picks the outermost segments whenever the breakpoints are ascending. The bench scenarios are needed for the rest: the rounded multiply-add values, clamping at both rails, inputs exactly on a breakpoint, the address map including ignored addresses, and the exact moment a streamed-in coefficient update becomes visible.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    CFG_SLOPE = 2'd0,
    CFG_ICPT  = 2'd1,
    CFG_BRK   = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_kind_e;

  typedef struct packed {
    cfg_kind_e  kind;
    logic [7:0] idx;
  } cfg_target_t;

  // Address layout: slopes, then intercepts, then the (nseg-1) breakpoints.
  function automatic cfg_target_t decode_cfg(input int unsigned addr, input int unsigned nseg);
    cfg_target_t t;
    if (addr < nseg) begin
      t.kind = CFG_SLOPE;
      t.idx  = 8'(addr);
    end else if (addr < 2 * nseg) begin
      t.kind = CFG_ICPT;
      t.idx  = 8'(addr - nseg);
    end else if (addr < 3 * nseg - 1) begin
      t.kind = CFG_BRK;
      t.idx  = 8'(addr - 2 * nseg);
    end else begin
      t.kind = CFG_NONE;
      t.idx  = 8'd0;
    end
    return t;
  endfunction

endpackage

// File: rtl/pla_coef_bank.sv
module pla_coef_bank
  import pla_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NSEG = 16,
  parameter int AW   = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     busy,
  input  logic                     cfg_we,
  input  logic [AW-1:0]            cfg_addr,
  input  logic [DW-1:0]            cfg_wdata,
  output logic [NSEG*DW-1:0]       act_a_flat,
  output logic [NSEG*DW-1:0]       act_b_flat,
  output logic [(NSEG-1)*DW-1:0]   act_bp_flat
);

  localparam int NBRK = NSEG - 1;

  cfg_target_t tgt;
  assign tgt = decode_cfg(32'(cfg_addr), NSEG);

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_seg
      logic [DW-1:0] sh_a, sh_b, ac_a, ac_b;

      always_ff @(posedge clk) begin
        if (rst) begin
          sh_a <= '0;
          sh_b <= '0;
          ac_a <= '0;
          ac_b <= '0;
        end else begin
          if (cfg_we && tgt.kind == CFG_SLOPE && tgt.idx == 8'(g)) sh_a <= cfg_wdata;
          if (cfg_we && tgt.kind == CFG_ICPT  && tgt.idx == 8'(g)) sh_b <= cfg_wdata;
          if (!busy) begin
            ac_a <= sh_a;
            ac_b <= sh_b;
          end
        end
      end

      assign act_a_flat[g*DW +: DW] = ac_a;
      assign act_b_flat[g*DW +: DW] = ac_b;
    end

    for (g = 0; g < NBRK; g++) begin : g_brk
      logic [DW-1:0] sh_bp, ac_bp;

      always_ff @(posedge clk) begin
        if (rst) begin
          sh_bp <= '0;
          ac_bp <= '0;
        end else begin
          if (cfg_we && tgt.kind == CFG_BRK && tgt.idx == 8'(g)) sh_bp <= cfg_wdata;
          if (!busy) ac_bp <= sh_bp;
        end
      end

      assign act_bp_flat[g*DW +: DW] = ac_bp;
    end
  endgenerate

  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(act_a_flat) && $stable(act_b_flat) && $stable(act_bp_flat))); // R8

endmodule

// File: rtl/pla_seg_select.sv
module pla_seg_select #(
  parameter int DW   = 16,
  parameter int NSEG = 16,
  parameter int SW   = 4
) (
  input  logic signed [DW-1:0]       x,
  input  logic [(NSEG-1)*DW-1:0]     bp_flat,
  output logic [SW-1:0]              seg
);

  // Count of breakpoints at or below x; for ascending breakpoints this is
  // the index of the interval [bp[k-1], bp[k]) containing x.
  always_comb begin
    seg = '0;
    for (int k = 0; k < NSEG - 1; k++) begin
      if (x >= $signed(bp_flat[k*DW +: DW])) seg = seg + SW'(1);
    end
  end

endmodule

// File: rtl/pla_mac.sv
module pla_mac #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic                 byp_in,
  input  logic [DW-1:0]        x_in,
  input  logic [DW-1:0]        a_in,
  input  logic [DW-1:0]        b_in,
  output logic [DW-1:0]        y_out
);

  localparam int PW = 2 * DW;
  localparam logic signed [PW-1:0] HALF = PW'(2 ** (FRAC - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [PW-1:0] xe, ae, be, prod, rnd, shf, sum;
  logic [DW-1:0]        y_n;

  always_comb begin
    xe   = {{DW{x_in[DW-1]}}, x_in};
    ae   = {{DW{a_in[DW-1]}}, a_in};
    be   = {{DW{b_in[DW-1]}}, b_in};
    prod = xe * ae;
    rnd  = prod + HALF;
    shf  = rnd >>> FRAC;
    sum  = shf + be;
    if (byp_in)           y_n = x_in;
    else if (sum > MAXV)  y_n = MAXV[DW-1:0];
    else if (sum < MINV)  y_n = MINV[DW-1:0];
    else                  y_n = sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       y_out <= '0;
    else if (v_in) y_out <= y_n;
  end

  AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (rst)
    (v_in && byp_in) |=> (y_out == $past(x_in))); // R6

endmodule

// File: rtl/pla_activation.sv
module pla_activation
  import pla_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int FRAC  = 8,
  parameter int NSEG  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       in_bypass,
  input  logic [LANES*DW-1:0]        in_data,
  input  logic                       cfg_we,
  input  logic [$clog2(3*NSEG)-1:0]  cfg_addr,
  input  logic [DW-1:0]              cfg_wdata,
  output logic                       out_valid,
  output logic [LANES*DW-1:0]        out_data
);

  localparam int NBRK = NSEG - 1;
  localparam int SW   = $clog2(NSEG);
  localparam int AW   = $clog2(3 * NSEG);

  logic [NSEG*DW-1:0] act_a_flat, act_b_flat;
  logic [NBRK*DW-1:0] act_bp_flat;

  pla_coef_bank #(.DW(DW), .NSEG(NSEG), .AW(AW)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .busy       (in_valid),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .act_a_flat (act_a_flat),
    .act_b_flat (act_b_flat),
    .act_bp_flat(act_bp_flat)
  );

  // Stage 1 control
  logic s1_valid, s1_byp;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_byp    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      if (in_valid) s1_byp <= in_bypass;
      out_valid <= s1_valid;
    end
  end

  // Breakpoint ordering flag, used only to qualify the segment checks
  logic bp_ascending;
  always_comb begin
    bp_ascending = 1'b1;
    for (int k = 0; k < NBRK - 1; k++) begin
      if ($signed(act_bp_flat[k*DW +: DW]) > $signed(act_bp_flat[(k+1)*DW +: DW]))
        bp_ascending = 1'b0;
    end
  end

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      logic signed [DW-1:0] x_l;
      logic [SW-1:0]        seg;
      logic [DW-1:0]        a_sel, b_sel;
      logic [DW-1:0]        s1_x, s1_a, s1_b;

      assign x_l = in_data[l*DW +: DW];

      pla_seg_select #(.DW(DW), .NSEG(NSEG), .SW(SW)) u_sel (
        .x      (x_l),
        .bp_flat(act_bp_flat),
        .seg    (seg)
      );

      assign a_sel = act_a_flat[int'(seg)*DW +: DW];
      assign b_sel = act_b_flat[int'(seg)*DW +: DW];

      // Coefficients are captured with the data, so stage 2 never sees an update.
      always_ff @(posedge clk) begin
        if (rst) begin
          s1_x <= '0;
          s1_a <= '0;
          s1_b <= '0;
        end else if (in_valid) begin
          s1_x <= x_l;
          s1_a <= a_sel;
          s1_b <= b_sel;
        end
      end

      pla_mac #(.DW(DW), .FRAC(FRAC)) u_mac (
        .clk   (clk),
        .rst   (rst),
        .v_in  (s1_valid),
        .byp_in(s1_byp),
        .x_in  (s1_x),
        .a_in  (s1_a),
        .b_in  (s1_b),
        .y_out (out_data[l*DW +: DW])
      );

      AST_SEG_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bp_ascending && (x_l < $signed(act_bp_flat[0 +: DW])))
        |-> (seg == '0)); // R3
      AST_SEG_CEIL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bp_ascending && (x_l >= $signed(act_bp_flat[(NBRK-1)*DW +: DW])))
        |-> (seg == SW'(NSEG - 1))); // R3
    end
  endgenerate

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid); // R2

endmodule

// File: tb/tb_pla_activation.sv
`timescale 1ns/1ps
module tb_pla_activation;

  localparam int LANES = 4;
  localparam int DW    = 16;
  localparam int VW    = LANES * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_bypass = 1'b0;
  logic [VW-1:0] in_data = '0;
  logic          cfg_we = 1'b0;
  logic [5:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          out_valid;
  logic [VW-1:0] out_data;

  always #10 clk = ~clk;

  pla_activation dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bypass(in_bypass),
    .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model: committed (m_) and pending (s_) coefficient sets
  logic signed [15:0] m_a[16], m_b[16], m_bp[15];
  logic signed [15:0] s_a[16], s_b[16], s_bp[15];

  // Expected-result pipe, two entries deep
  bit            pv[2];
  logic [VW-1:0] pd[2];
  string         pt[2];

  function automatic logic [15:0] model_lane(logic signed [15:0] x, bit byp);
    int seg;
    longint p, r, s;
    if (byp) return x;
    seg = 0;
    for (int k = 0; k < 15; k++) if (x >= m_bp[k]) seg++;
    p = longint'(m_a[seg]) * longint'(x);
    r = (p + 128) >>> 8;
    s = r + longint'(m_b[seg]);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return 16'(s);
  endfunction

  task automatic report;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step(input bit v, input bit byp, input logic [VW-1:0] x,
                      input bit we, input logic [5:0] addr, input logic [15:0] wd,
                      input string tag);
    logic [VW-1:0] e;
    @(negedge clk);
    n_chk++;
    if (out_valid !== pv[1] || (pv[1] && out_data !== pd[1])) begin
      n_fail++;
      $display("FAIL %s: out_valid=%0b out_data=%h expected valid=%0b data=%h",
               pt[1], out_valid, out_data, pv[1], pd[1]);
    end
    for (int i = 0; i < LANES; i++) e[i*16 +: 16] = model_lane(x[i*16 +: 16], byp);
    in_valid = v; in_bypass = byp; in_data = x;
    cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
    pv[1] = pv[0]; pd[1] = pd[0]; pt[1] = pt[0];
    pv[0] = v; pd[0] = e; pt[0] = v ? tag : "R2";
    if (!v) begin
      for (int i = 0; i < 16; i++) begin m_a[i] = s_a[i]; m_b[i] = s_b[i]; end
      for (int i = 0; i < 15; i++) m_bp[i] = s_bp[i];
    end
    if (we) begin
      if (addr < 16)      s_a[addr] = wd;
      else if (addr < 32) s_b[addr - 16] = wd;
      else if (addr < 47) s_bp[addr - 32] = wd;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, '0, '0, "R2");
  endtask

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) begin
      if ($urandom_range(0, 3) == 0) v[i*16 +: 16] = 16'($urandom);
      else v[i*16 +: 16] = 16'(int'($urandom_range(0, 9000)) - 4500);
    end
    return v;
  endfunction

  // Load a fresh random ascending set; streaming keeps in_valid high throughout
  task automatic program_set(input bit streaming, input string tag);
    logic [15:0] val;
    for (int ad = 0; ad < 47; ad++) begin
      if (ad < 16)      val = 16'(int'($urandom_range(0, 2047)) - 1024);
      else if (ad < 32) val = 16'(int'($urandom_range(0, 8191)) - 4096);
      else              val = 16'(-3600 + (ad - 32) * 500 + int'($urandom_range(0, 199)));
      step(streaming, 0, rand_vec(), 1, 6'(ad), val, tag);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    report();
  end

  initial begin
    logic [VW-1:0] v;
    void'($urandom(32'd5150));
    for (int i = 0; i < 16; i++) begin m_a[i] = 0; m_b[i] = 0; s_a[i] = 0; s_b[i] = 0; end
    for (int i = 0; i < 15; i++) begin m_bp[i] = 0; s_bp[i] = 0; end
    for (int i = 0; i < 2; i++) begin pv[i] = 0; pd[i] = '0; pt[i] = "R2"; end

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      n_fail++;
      $display("FAIL R1: out_valid=%0b out_data=%h expected valid=0 data=0", out_valid, out_data);
    end
    // R1: zero coefficients give zero results
    step(1, 0, 64'h1234_8000_7FFF_0100, 0, '0, '0, "R1");
    step(1, 0, rand_vec(), 0, '0, '0, "R1");
    idle(3);

    program_set(0, "R4");
    idle(2);

    // R3: inputs on, just under, and outside the breakpoints
    for (int k = 0; k < 15; k++) begin
      v[15:0]  = m_bp[k];
      v[31:16] = 16'(m_bp[k] - 16'sd1);
      v[47:32] = 16'h8000;
      v[63:48] = 16'h7FFF;
      step(1, 0, v, 0, '0, '0, "R3");
    end
    // R9: lanes land in distinct segments within one vector
    v = {16'(m_bp[14]), 16'(m_bp[9]), 16'(m_bp[4]), 16'(m_bp[0] - 16'sd5)};
    step(1, 0, v, 0, '0, '0, "R9");
    v = {v[15:0], v[63:16]};
    step(1, 0, v, 0, '0, '0, "R9");
    idle(2);

    // R4 / R6: random traffic with gaps and pooling bypass
    for (int i = 0; i < 400; i++) begin
      bit vb, bb;
      vb = ($urandom_range(0, 4) != 0);
      bb = ($urandom_range(0, 7) == 0);
      step(vb, bb, rand_vec(), 0, '0, '0, bb ? "R6" : "R4");
    end
    idle(2);

    // R5: saturation at both rails
    step(0, 0, '0, 1, 6'd15, 16'h7FFF, "R5");
    step(0, 0, '0, 1, 6'd31, 16'h7F00, "R5");
    step(0, 0, '0, 1, 6'd0,  16'h7FFF, "R5");
    step(0, 0, '0, 1, 6'd16, 16'h8100, "R5");
    idle(2);
    step(1, 0, {4{16'h7FFF}}, 0, '0, '0, "R5");
    step(1, 0, {4{16'h8000}}, 0, '0, '0, "R5");
    step(1, 0, {16'h7FFF, 16'h8000, 16'h7000, 16'h9000}, 0, '0, '0, "R5");
    idle(2);

    // R7: writes beyond the map are dropped
    for (int ad = 47; ad < 64; ad++) step(0, 0, '0, 1, 6'(ad), 16'($urandom), "R7");
    idle(2);
    for (int i = 0; i < 20; i++) step(1, 0, rand_vec(), 0, '0, '0, "R7");
    idle(2);

    // R8: reprogram while streaming; old set stays in use until a gap
    program_set(1, "R8");
    for (int i = 0; i < 10; i++) step(1, 0, rand_vec(), 0, '0, '0, "R8");
    idle(2);
    for (int i = 0; i < 30; i++) step(1, $urandom_range(0, 5) == 0, rand_vec(), 0, '0, '0, "R8");
    idle(3);

    report();
  end

endmodule